// File: doc/BRIEF.md
# Half to E5M2 FP8 vector converter

This block converts a vector of up to 32 lanes between 16-bit half precision and the 8-bit E5M2 floating-point format (sign, 5-bit exponent, 2-bit fraction). A direction input picks the conversion. Narrowing from half to E5M2 rounds to nearest with ties to even and keeps subnormals. Widening from E5M2 to half is exact. Every lane has a 16-bit slot in the packed source and destination vectors. An E5M2 value sits in bits 7:0 of its slot. A narrowed result also has bits 15:8 cleared.

A beat is offered by raising `in_valid` together with the direction, the 8-bit size/mode control byte, the channel enables and the source vector. There is no back-pressure and no ready signal: the block takes a beat on every cycle in which `in_valid` is high. One cycle later it updates the destination register and pulses `out_valid` for one cycle. The downstream side must take each result on the cycle `out_valid` is high. Each lane is written only if it is active and its write condition holds. Every other lane keeps its previous contents, so the destination works as a partially updated register.

Top module: `hf8_vec_cvt`

## Requirements
- R1: When narrowing, a lane's result is the upper byte of the half value (bits 15:8), plus one when bit 7 is set and either bit 8 or any of bits 6:0 is set. The result goes in slot bits 7:0, and bits 15:8 are written as zero.
- R2: Subnormal values are kept in both directions and never flushed. For example, half 0x00C0 narrows to 0x01, half 0x0180 narrows to 0x02, and E5M2 0x03 widens to half 0x0300.
- R3: A half NaN (exponent 11111, nonzero fraction) narrows to its upper byte with bit 1 forced to 1, and is never rounded. Half infinities 0x7C00 and 0xFC00 narrow to 0x7C and 0xFC.
- R4: A finite half value that rounds above the largest finite E5M2 magnitude becomes a signed infinity. For example, 0x7BFF gives 0x7C and 0xFBFF gives 0xFC.
- R5: Widening (to_fp8 = 0) writes the half value {src[7:0], 8'h00} into the lane.
- R6: Control bits 2:0 set the active lane count to 2^code for codes 0 to 5: lanes 0 to 2^code - 1 are active. Codes 6 and 7 make no lane active.
- R7: When widening with control bit 7 clear, an active lane is written only if its channel-enable bit is set.
- R8: Control bit 7 set (no-mask mode) makes every active lane act as enabled.
- R9: When narrowing (to_fp8 = 1), every active lane is written whatever the channel enables hold.
- R10: Lanes that are inactive or not written keep their previous destination contents.
- R11: `out_valid` goes high in the cycle after a beat with `in_valid` high, and only then. The destination does not change in a cycle that follows one without a beat.
- R12: After reset the destination vector is all zero and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Beat offered this cycle |
| to_fp8 | input | 1 | 1 narrows half to E5M2, 0 widens E5M2 to half |
| size_ctl | input | 8 | Bits 2:0 lane-count code, bit 7 no-mask mode |
| ch_en | input | LANES | Per-lane channel enables |
| src_data | input | LANES*16 | Packed source, lane i in bits 16i+15:16i |
| dst_data | output | LANES*16 | Packed destination register |
| out_valid | output | 1 | Destination was updated by the previous beat |

## Verification
The bench builds the block with its default of 32 lanes. This covers every lane-count code, including the full 32-lane width and the two illegal codes, and it exercises the hold behaviour of the upper lanes at each smaller count. Fixed half values are placed in low lanes to hit exact ties on both odd and even LSBs, subnormal rounding, NaN and infinity inputs, and overflow to infinity. Random beats then check rounding across the whole input space against a separate model of the arithmetic.

// File: rtl/hf8_pkg.sv
package hf8_pkg;
  localparam int HALF_W = 16;
  localparam int FP8_W  = 8;
  localparam int SIZE_W = 8;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [FP8_W-1:0]  fp8_t;
endpackage

// File: rtl/hf8_lane_ctl.sv
module hf8_lane_ctl
  import hf8_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [SIZE_W-1:0] size_ctl,
  input  logic [LANES-1:0]  ch_en,
  input  logic              to_fp8,
  output logic [LANES-1:0]  wr_en
);
  localparam int CNT_W = $clog2(LANES) + 2;

  logic [2:0]       code;
  logic             legal;
  logic             no_mask;
  logic [CNT_W-1:0] count;

  assign code    = size_ctl[2:0];
  assign legal   = (code <= 3'd5);
  assign no_mask = size_ctl[7];

  always_comb begin
    count = '0;
    if (legal) count = CNT_W'(1) << code;
  end

  // R6 active range, R7/R8/R9 enable override
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr_en[i] = (CNT_W'(i) < count) && (ch_en[i] || no_mask || to_fp8);
    end
  end
endmodule

// File: rtl/hf8_lane_cvt.sv
module hf8_lane_cvt
  import hf8_pkg::*;
(
  input  half_t src,
  input  logic  to_fp8,
  output half_t res
);
  fp8_t top;
  logic is_nan;
  logic lsb, guard, sticky, bump;
  fp8_t narrow;

  assign top    = src[15:8];
  assign is_nan = (src[14:10] == 5'h1f) && (src[9:0] != '0);
  assign lsb    = src[8];
  assign guard  = src[7];
  assign sticky = |src[6:0];
  assign bump   = guard && (sticky || lsb);

  // R1/R2/R4 rounding, carry into exponent gives infinity; R3 NaN stays quiet
  always_comb begin
    if (is_nan) narrow = {top[7:2], 1'b1, top[0]};
    else        narrow = top + fp8_t'(bump);
  end

  // R5 widening is a plain shift
  assign res = to_fp8 ? {8'h00, narrow} : {src[7:0], 8'h00};
endmodule

// File: rtl/hf8_vec_cvt.sv
module hf8_vec_cvt
  import hf8_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    to_fp8,
  input  logic [SIZE_W-1:0]       size_ctl,
  input  logic [LANES-1:0]        ch_en,
  input  logic [LANES*HALF_W-1:0] src_data,
  output logic [LANES*HALF_W-1:0] dst_data,
  output logic                    out_valid
);
  logic [LANES-1:0]             wr_en;
  logic [LANES-1:0][HALF_W-1:0] lane_res;
  logic [LANES-1:0][HALF_W-1:0] dst_q;
  logic                         vld_q;

  hf8_lane_ctl #(.LANES(LANES)) u_ctl (
    .size_ctl (size_ctl),
    .ch_en    (ch_en),
    .to_fp8   (to_fp8),
    .wr_en    (wr_en)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hf8_lane_cvt u_cvt (
      .src    (src_data[g*HALF_W +: HALF_W]),
      .to_fp8 (to_fp8),
      .res    (lane_res[g])
    );
  end

  // R10 unwritten lanes hold, R11 one-cycle latency, R12 reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      for (int i = 0; i < LANES; i++) begin
        if (in_valid && wr_en[i]) dst_q[i] <= lane_res[i];
      end
    end
  end

  assign dst_data  = dst_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/hf8_vec_cvt_chk.sv
module hf8_vec_cvt_chk
  import hf8_pkg::*;
#(
  parameter int LANES = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    to_fp8,
  input logic [SIZE_W-1:0]       size_ctl,
  input logic [LANES-1:0]        ch_en,
  input logic [LANES*HALF_W-1:0] src_data,
  input logic [LANES*HALF_W-1:0] dst_data,
  input logic                    out_valid
);
  logic legal;
  assign legal = (size_ctl[2:1] != 2'b11);

  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dst_data));

  p_illegal_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> $stable(dst_data));

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && to_fp8) |=> (dst_data[15:8] == 8'h00));

  p_nan_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && to_fp8 && src_data[14:10] == 5'h1f && src_data[9:0] != 10'h0)
    |=> (dst_data[6:2] == 5'h1f && dst_data[1]));

  p_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal && !to_fp8 && (ch_en[0] || size_ctl[7]))
    |=> (dst_data[15:0] == {$past(src_data[7:0]), 8'h00}));

  p_single_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_ctl[2:0] == 3'd0)
    |=> $stable(dst_data[LANES*HALF_W-1:HALF_W]));
endmodule

bind hf8_vec_cvt hf8_vec_cvt_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .to_fp8    (to_fp8),
  .size_ctl  (size_ctl),
  .ch_en     (ch_en),
  .src_data  (src_data),
  .dst_data  (dst_data),
  .out_valid (out_valid)
);

// File: tb/tb_hf8_vec_cvt.sv
module tb_hf8_vec_cvt;
  localparam int LANES = 32;
  localparam int W = 16;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  in_valid = 1'b0;
  logic                  to_fp8 = 1'b0;
  logic [7:0]            size_ctl = '0;
  logic [LANES-1:0]      ch_en = '0;
  logic [LANES-1:0][W-1:0] src = '0;
  logic [LANES*W-1:0]    dst_data;
  logic                  out_valid;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] shadow [LANES];
  logic [LANES*W-1:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  hf8_vec_cvt #(.LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .to_fp8(to_fp8),
    .size_ctl(size_ctl), .ch_en(ch_en), .src_data(src),
    .dst_data(dst_data), .out_valid(out_valid)
  );

  function automatic logic [7:0] ref_narrow(input logic [15:0] h);
    int keep, rem;
    if (h[14:10] == 5'h1f && h[9:0] != 0) return h[15:8] | 8'h02;
    keep = int'(h[15:8]);
    rem  = int'(h[7:0]);
    if (rem > 128 || (rem == 128 && keep % 2 == 1)) keep = keep + 1;
    return keep[7:0];
  endfunction

  task automatic check(input string req, input logic [LANES*W-1:0] act,
                       input logic [LANES*W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic dir, input logic [7:0] ctl,
                      input logic [LANES-1:0] en, input logic [LANES-1:0][W-1:0] s);
    int cnt;
    logic [LANES*W-1:0] e;
    @(negedge clk);
    cnt = (ctl[2:0] <= 3'd5) ? (1 << ctl[2:0]) : 0;
    for (int i = 0; i < LANES; i++) begin
      if (i < cnt && (en[i] || ctl[7] || dir))
        shadow[i] = dir ? {8'h00, ref_narrow(s[i])} : {s[i][7:0], 8'h00};
      e[i*W +: W] = shadow[i];
    end
    exp_q.push_back(e);
    tag_q.push_back(req);
    in_valid = 1'b1; to_fp8 = dir; size_ctl = ctl; ch_en = en; src = s;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // monitor: compare each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11 actual=unexpected out_valid expected=none");
      end else begin
        string t;
        logic [LANES*W-1:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, dst_data, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [LANES-1:0][W-1:0] v;
    for (int i = 0; i < LANES; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 dst", dst_data, '0);
    check("R12 valid", {{(LANES*W-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed narrowing corners, enables all clear (R9)
    for (int i = 0; i < LANES; i++) v[i] = 16'($urandom);
    v[0] = 16'h3C00; v[1] = 16'h3C80; v[2] = 16'h3D80; v[3] = 16'h3C81;
    v[4] = 16'h7BFF; v[5] = 16'hFBFF; v[6] = 16'h7E00; v[7] = 16'h7C01;
    v[8] = 16'h7C00; v[9] = 16'hFC00; v[10] = 16'h00C0; v[11] = 16'h0180;
    v[12] = 16'h0080; v[13] = 16'h0001;
    send("R1 R9 narrow corners", 1'b1, 8'h05, '0, v);
    idle(3);
    check("R1 tie even",  {480'h0, dst_data[16 +: 16]},  {480'h0, 16'h003C});
    check("R1 tie odd",   {480'h0, dst_data[32 +: 16]},  {480'h0, 16'h003E});
    check("R1 above tie", {480'h0, dst_data[48 +: 16]},  {480'h0, 16'h003D});
    check("R4 pos overflow", {480'h0, dst_data[64 +: 16]}, {480'h0, 16'h007C});
    check("R4 neg overflow", {480'h0, dst_data[80 +: 16]}, {480'h0, 16'h00FC});
    check("R3 nan", {480'h0, dst_data[96 +: 16]},  {480'h0, 16'h007E});
    check("R3 nan low", {480'h0, dst_data[112 +: 16]}, {480'h0, 16'h007E});
    check("R3 inf", {480'h0, dst_data[128 +: 16]}, {480'h0, 16'h007C});
    check("R2 subnormal", {480'h0, dst_data[160 +: 16]}, {480'h0, 16'h0001});
    check("R2 subnormal odd", {480'h0, dst_data[176 +: 16]}, {480'h0, 16'h0002});

    // R11 hold during idle
    idle(4);
    check("R11 idle hold", {480'h0, dst_data[160 +: 16]}, {480'h0, 16'h0001});

    // Widening with masking (R5 R7), then no-mask (R8), subnormal widen (R2)
    for (int i = 0; i < LANES; i++) v[i] = 16'($urandom);
    v[0] = 16'h0003;
    send("R5 R7 widen masked", 1'b0, 8'h05, 32'hA5C3_0F19, v);
    for (int i = 0; i < LANES; i++) v[i] = 16'($urandom);
    send("R8 widen no-mask", 1'b0, 8'h85, 32'h0000_0000, v);
    v[0] = 16'h0003;
    send("R2 widen subnormal", 1'b0, 8'h80, '0, v);
    idle(3);
    check("R2 widen 0x03", {480'h0, dst_data[0 +: 16]}, {480'h0, 16'h0300});

    // Lane counts (R6 R10)
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < LANES; i++) v[i] = 16'($urandom);
      send((c >= 6) ? "R6 illegal size" : "R6 R10 lane count",
           c[0], {5'b10000, c[2:0]}, 32'hFFFF_FFFF, v);
    end
    idle(2);

    // Random mixed beats
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < LANES; i++) v[i] = 16'($urandom);
      send("R1 R7 R10 random", 1'($urandom), {1'($urandom), 4'h0, 3'($urandom_range(0, 7))},
           32'($urandom), v);
      if (k % 5 == 0) idle(2);
    end
    idle(4);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R11 actual=%0d pending expected=0", exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule